// File: doc/BRIEF.md
# Programmable Parallel Expansion Bus Sequencer

This block is the master side of a memory-mapped parallel expansion bus with eight chip selects. It takes one single-beat read or write request at a time. The request carries a chip select, a byte offset within that bank, write data and byte enables. The block then sequences the external address, data, chip-select, byte-lane and strobe pins.

Every access walks through five phases in fixed order: address, setup, strobe, hold and recovery. Each phase lasts one base cycle plus an extension taken from that chip select's configuration. Each chip select also chooses:
- the strobe style: separate read/write strobes, one data strobe with a direction line, or host-port cycles that wait on a ready pin of programmable polarity;
- whether the address is multiplexed onto the data lines;
- an 8-bit or 16-bit data path;
- whether writes are permitted;
- whether byte reads reach a 16-bit device as single-byte reads.

All configuration arrives on static input ports, packed per chip select. Chip select `n` owns the field `[n*W +: W]` of each configuration vector.

Top module: `xbus_seq`

## Requirements
- R1: An accepted access runs the phases address, setup, strobe, hold and recovery strictly in that order, then returns to idle.
- R2: Each phase lasts 1 + its extension in cycles. The extensions are 2 bits for address, setup and hold, and 4 bits for strobe and recovery. With all extensions zero an access lasts exactly 5 cycles.
- R3: Exactly one `bus_cs_n` bit, the one for the addressed chip select, is low during the setup, strobe and hold phases. All bits are high during the address and recovery phases and while idle. No strobe is active outside that window.
- R4: Cycle type 0 (`cfg_cycle` field = 0) pulses `bus_rd_n` low for reads or `bus_wr_n` low for writes during the strobe phase. `bus_ds_n` stays high.
- R5: Cycle type 1 pulses `bus_ds_n` low during the strobe phase, with `bus_rnw` high for reads and low for writes. `bus_rd_n` and `bus_wr_n` stay high.
- R6: Cycle types 2 and 3 strobe like type 1. However, the strobe phase ends only after its 1 + extension cycles have elapsed and `bus_rdy` has been sampled active in the same or a later cycle. `bus_rdy` is active high when the chip select's `cfg_rdy_high` bit is 1 and active low when it is 0.
- R7: When the chip select's `cfg_mux` bit is 1, `bus_dout` carries offset bits [15:0] with `bus_doe` high during the address phase, for reads and writes alike. In later phases it carries write data, or is released for reads.
- R8: When `cfg_narrow` is 1, the device is 8 bits wide: `bus_be_n` = 2'b10, writes drive `{8'h00, wdata[7:0]}`, and `rd_data` = `{8'h00, bus_din[7:0]}`. When it is 0, all 16 bits are used and `bus_be_n` = ~`req_be` for writes.
- R9: A write request to a chip select whose `cfg_wr_en` bit is 0 is dropped. `busy` stays low, and no chip select, strobe, data enable or address pin changes.
- R10: On a 16-bit device, a read drives `bus_be_n` = ~`req_be` when `cfg_byte_rd` is 1. When it is 0, the read is widened to a halfword and `bus_be_n` = 2'b00.
- R11: `busy` is high from the cycle after acceptance to the last recovery cycle. A request presented while `busy` is high, including during the last recovery cycle, is ignored.
- R12: A read returns `rd_data` sampled at the end of the last strobe cycle, with a single-cycle `rd_valid` in the first hold cycle. Writes produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Target chip select |
| req_off | input | OFFW | Byte offset within the bank |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| cfg_addr_ext | input | 2*NCS | Address phase extension per chip select |
| cfg_setup_ext | input | 2*NCS | Setup phase extension per chip select |
| cfg_strobe_ext | input | 4*NCS | Strobe phase extension per chip select |
| cfg_hold_ext | input | 2*NCS | Hold phase extension per chip select |
| cfg_recov_ext | input | 4*NCS | Recovery phase extension per chip select |
| cfg_cycle | input | 2*NCS | Strobe style per chip select |
| cfg_rdy_high | input | NCS | Ready polarity, 1 = active high |
| cfg_mux | input | NCS | Address on data lines in the address phase |
| cfg_narrow | input | NCS | 8-bit device when 1 |
| cfg_wr_en | input | NCS | Writes permitted when 1 |
| cfg_byte_rd | input | NCS | Byte reads kept narrow on 16-bit devices |
| bus_addr | output | OFFW | External address |
| bus_cs_n | output | NCS | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_be_n | output | 2 | Byte lane enables, active low |
| bus_dout | output | 16 | Data/address out |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Data in |
| bus_rdy | input | 1 | Host-port ready |

## Verification
In host-port mode, the end of the strobe count and the arrival of ready can land in the same cycle. The bench raises ready exactly on the last counted strobe cycle, and separately several cycles later. It then checks that the strobe lasts 1 + extension cycles in the first case and stretches to the ready cycle in the second. A second collision is a new request offered in the final recovery cycle, while `busy` is still high. It is judged by `busy` staying low afterwards and `bus_addr` keeping the old offset.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int NCS  = 8,
  parameter int OFFW = 24,
  localparam int CSW = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [OFFW-1:0]   req_off,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              busy,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  input  logic [2*NCS-1:0]  cfg_addr_ext,
  input  logic [2*NCS-1:0]  cfg_setup_ext,
  input  logic [4*NCS-1:0]  cfg_strobe_ext,
  input  logic [2*NCS-1:0]  cfg_hold_ext,
  input  logic [4*NCS-1:0]  cfg_recov_ext,
  input  logic [2*NCS-1:0]  cfg_cycle,
  input  logic [NCS-1:0]    cfg_rdy_high,
  input  logic [NCS-1:0]    cfg_mux,
  input  logic [NCS-1:0]    cfg_narrow,
  input  logic [NCS-1:0]    cfg_wr_en,
  input  logic [NCS-1:0]    cfg_byte_rd,
  output logic [OFFW-1:0]   bus_addr,
  output logic [NCS-1:0]    bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_ds_n,
  output logic              bus_rnw,
  output logic [1:0]        bus_be_n,
  output logic [15:0]       bus_dout,
  output logic              bus_doe,
  input  logic [15:0]       bus_din,
  input  logic              bus_rdy
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SETUP, S_STB, S_HOLD, S_RECOV} phase_t;

  phase_t          st, st_nxt;
  logic [3:0]      cnt, ext_nxt;
  logic [CSW-1:0]  cs_q;
  logic [OFFW-1:0] off_q;
  logic [15:0]     wd_q;
  logic [1:0]      be_q;
  logic            wr_q;

  logic [1:0] mode;
  logic       hp, dstyle, narrow, rdy_act, phase_end, accept, cs_act, stb;

  assign mode    = cfg_cycle[cs_q*2 +: 2];
  assign hp      = mode[1];
  assign dstyle  = (mode != 2'd0);
  assign narrow  = cfg_narrow[cs_q];
  assign rdy_act = (bus_rdy == cfg_rdy_high[cs_q]);
  assign accept  = req_valid && (st == S_IDLE) && (!req_write || cfg_wr_en[req_cs]);

  always_comb begin
    st_nxt  = S_IDLE;
    ext_nxt = 4'd0;
    case (st)
      S_ADDR:  begin st_nxt = S_SETUP; ext_nxt = {2'b00, cfg_setup_ext[cs_q*2 +: 2]}; end
      S_SETUP: begin st_nxt = S_STB;   ext_nxt = cfg_strobe_ext[cs_q*4 +: 4]; end
      S_STB:   begin st_nxt = S_HOLD;  ext_nxt = {2'b00, cfg_hold_ext[cs_q*2 +: 2]}; end
      S_HOLD:  begin st_nxt = S_RECOV; ext_nxt = cfg_recov_ext[cs_q*4 +: 4]; end
      default: begin st_nxt = S_IDLE;  ext_nxt = 4'd0; end
    endcase
  end

  assign phase_end = (cnt == 4'd0) && ((st != S_STB) || !hp || rdy_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= 4'd0;
      cs_q     <= '0;
      off_q    <= '0;
      wd_q     <= 16'h0;
      be_q     <= 2'b00;
      wr_q     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 16'h0;
    end else begin
      rd_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (accept) begin
          st    <= S_ADDR;
          cnt   <= {2'b00, cfg_addr_ext[req_cs*2 +: 2]};
          cs_q  <= req_cs;
          off_q <= req_off;
          wd_q  <= req_wdata;
          be_q  <= req_be;
          wr_q  <= req_write;
        end
      end else if (cnt != 4'd0) begin
        cnt <= cnt - 4'd1;
      end else if (phase_end) begin
        st  <= st_nxt;
        cnt <= ext_nxt;
        if (st == S_STB && !wr_q) begin
          rd_valid <= 1'b1;
          rd_data  <= narrow ? {8'h00, bus_din[7:0]} : bus_din;
        end
      end
    end
  end

  assign busy     = (st != S_IDLE);
  assign cs_act   = (st == S_SETUP) || (st == S_STB) || (st == S_HOLD);
  assign stb      = (st == S_STB);
  assign bus_addr = off_q;
  assign bus_cs_n = cs_act ? ~(NCS'(1) << cs_q) : '1;
  assign bus_rd_n = !(stb && !dstyle && !wr_q);
  assign bus_wr_n = !(stb && !dstyle && wr_q);
  assign bus_ds_n = !(stb && dstyle);
  assign bus_rnw  = !(busy && wr_q);
  assign bus_be_n = !busy ? 2'b11 :
                    narrow ? 2'b10 :
                    (wr_q || cfg_byte_rd[cs_q]) ? ~be_q : 2'b00;
  assign bus_dout = (st == S_ADDR && cfg_mux[cs_q]) ? 16'(off_q) :
                    narrow ? {8'h00, wd_q[7:0]} : wd_q;
  assign bus_doe  = ((st == S_ADDR) && (cfg_mux[cs_q] || wr_q)) || (wr_q && cs_act);

  p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> ((3'(st) == 3'($past(st)) + 3'd1) || ($past(st) == S_RECOV && st == S_IDLE)));

  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n || !bus_ds_n) |-> !(&bus_cs_n));

  p_rdy_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STB && hp && !rdy_act) |=> (st == S_STB));

  p_wr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_write && !cfg_wr_en[req_cs]) |=> !busy);

  p_rdv_after_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(st) == S_STB && !wr_q));

  p_rdv_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;
  localparam int NCS = 8;
  localparam int OFFW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [2:0] req_cs = 0;
  logic [OFFW-1:0] req_off = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0] req_be = 2'b11;
  logic busy, rd_valid;
  logic [15:0] rd_data;
  logic [15:0] c_t1 = 0, c_t2 = 0, c_t4 = 0, c_cyc = 0;
  logic [31:0] c_t3 = 0, c_t5 = 0;
  logic [7:0] c_pol = 0, c_mux = 0, c_nar = 0, c_wen = 0, c_brd = 0;
  logic [OFFW-1:0] bus_addr;
  logic [NCS-1:0] bus_cs_n;
  logic bus_rd_n, bus_wr_n, bus_ds_n, bus_rnw, bus_doe;
  logic [1:0] bus_be_n;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = 0;
  logic bus_rdy = 0;

  xbus_seq #(.NCS(NCS), .OFFW(OFFW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_off(req_off), .req_wdata(req_wdata), .req_be(req_be),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_addr_ext(c_t1), .cfg_setup_ext(c_t2), .cfg_strobe_ext(c_t3),
    .cfg_hold_ext(c_t4), .cfg_recov_ext(c_t5), .cfg_cycle(c_cyc),
    .cfg_rdy_high(c_pol), .cfg_mux(c_mux), .cfg_narrow(c_nar),
    .cfg_wr_en(c_wen), .cfg_byte_rd(c_brd),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ds_n(bus_ds_n), .bus_rnw(bus_rnw),
    .bus_be_n(bus_be_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_rdy(bus_rdy));

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setcs(input int cs, input int t1, input int t2, input int t3, input int t4,
                       input int t5, input int cyc, input bit pol, input bit mux,
                       input bit nar, input bit wen, input bit brd);
    c_t1[cs*2 +: 2] = 2'(t1); c_t2[cs*2 +: 2] = 2'(t2); c_t3[cs*4 +: 4] = 4'(t3);
    c_t4[cs*2 +: 2] = 2'(t4); c_t5[cs*4 +: 4] = 4'(t5); c_cyc[cs*2 +: 2] = 2'(cyc);
    c_pol[cs] = pol; c_mux[cs] = mux; c_nar[cs] = nar; c_wen[cs] = wen; c_brd[cs] = brd;
  endtask

  int n_busy, cs_first, cs_last, stb_first, stb_last, rv_cnt, rv_k, cs_bad;
  bit saw_rd, saw_wr, saw_ds, rnw_stb, doe_stb, doe_a;
  logic [1:0] be_stb;
  logic [15:0] dout_stb, dout_a, rv_data;

  task automatic run(input int cs, input bit wr, input logic [OFFW-1:0] off, input logic [15:0] wd,
                     input logic [1:0] be, input int rdy_k, input int extra_k);
    bit pol = c_pol[cs];
    n_busy = -1; cs_first = 0; cs_last = 0; stb_first = 0; stb_last = 0;
    rv_cnt = 0; rv_k = 0; cs_bad = 0;
    saw_rd = 0; saw_wr = 0; saw_ds = 0; rnw_stb = 0; doe_stb = 0; doe_a = 0;
    be_stb = 0; dout_stb = 0; dout_a = 0; rv_data = 0;
    bus_rdy = !pol;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_cs = 3'(cs); req_off = off; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 0;
    for (int k = 1; k < 300; k++) begin
      if (k == extra_k) begin
        req_valid = 1; req_write = 0; req_cs = 3'((cs + 1) % NCS); req_off = '1;
      end
      if (k == extra_k + 1) req_valid = 0;
      bus_rdy = (k >= rdy_k) ? pol : !pol;
      if (!busy) begin n_busy = k - 1; break; end
      if (k == 1) begin doe_a = bus_doe; dout_a = bus_dout; end
      if (bus_cs_n != 8'hFF) begin
        if (cs_first == 0) cs_first = k;
        cs_last = k;
        if (bus_cs_n != ~(8'(1) << cs)) cs_bad++;
      end
      if (!bus_rd_n || !bus_wr_n || !bus_ds_n) begin
        if (stb_first == 0) stb_first = k;
        stb_last = k;
        saw_rd |= !bus_rd_n; saw_wr |= !bus_wr_n; saw_ds |= !bus_ds_n;
        rnw_stb = bus_rnw; doe_stb = bus_doe; dout_stb = bus_dout; be_stb = bus_be_n;
        if (bus_cs_n == 8'hFF) cs_bad++;
      end
      if (rd_valid) begin rv_cnt++; rv_k = k; rv_data = rd_data; end
      @(negedge clk);
    end
    req_valid = 0;
    bus_rdy = !pol;
  endtask

  task automatic chk_phases(input string tag, input int a, input int s, input int t, input int h, input int r);
    chk(n_busy == a + s + t + h + r, {tag, " R2 total"}, n_busy, a + s + t + h + r);
    chk(cs_first - 1 == a, {tag, " R2 address"}, cs_first - 1, a);
    chk(stb_first - cs_first == s, {tag, " R1 setup"}, stb_first - cs_first, s);
    chk(stb_last - stb_first + 1 == t, {tag, " R2 strobe"}, stb_last - stb_first + 1, t);
    chk(cs_last - stb_last == h, {tag, " R1 hold"}, cs_last - stb_last, h);
    chk(n_busy - cs_last == r, {tag, " R2 recovery"}, n_busy - cs_last, r);
    chk(cs_bad == 0, {tag, " R3 chip select"}, cs_bad, 0);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R11 reset busy", busy, 0);
    chk(bus_cs_n == 8'hFF, "R3 reset cs", bus_cs_n, 8'hFF);
    chk({bus_rd_n, bus_wr_n, bus_ds_n} == 3'b111, "R3 reset strobes", {bus_rd_n, bus_wr_n, bus_ds_n}, 7);
    chk(rd_valid == 0 && bus_doe == 0, "R12 reset rd_valid/doe", {rd_valid, bus_doe}, 0);
  endtask

  task automatic t_type0_read;
    setcs(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    bus_din = 16'hA55A;
    run(0, 0, 24'h000010, 16'h0, 2'b11, 0, -5);
    chk_phases("type0 read R1", 1, 1, 1, 1, 1);
    chk(saw_rd && !saw_wr && !saw_ds, "R4 read strobe", {saw_rd, saw_wr, saw_ds}, 3'b100);
    chk(doe_a == 0 && doe_stb == 0, "R7 no mux read releases data", {doe_a, doe_stb}, 0);
    chk(rv_cnt == 1 && rv_k == 4, "R12 rd_valid cycle", rv_k, 4);
    chk(rv_data == 16'hA55A, "R12 rd_data", rv_data, 16'hA55A);
  endtask

  task automatic t_type0_write_max;
    setcs(7, 3, 2, 15, 3, 15, 0, 0, 0, 0, 1, 0);
    run(7, 1, 24'h00ABCD, 16'h5AA5, 2'b10, 0, -5);
    chk_phases("type0 write R2", 4, 3, 16, 4, 16);
    chk(saw_wr && !saw_rd && !saw_ds, "R4 write strobe", {saw_rd, saw_wr, saw_ds}, 3'b010);
    chk(doe_stb && dout_stb == 16'h5AA5, "R8 wide write data", dout_stb, 16'h5AA5);
    chk(be_stb == 2'b01, "R8 wide write lanes", be_stb, 2'b01);
    chk(rv_cnt == 0, "R12 no rd_valid on write", rv_cnt, 0);
  endtask

  task automatic t_type1_narrow;
    setcs(1, 0, 0, 3, 0, 0, 1, 0, 0, 1, 1, 0);
    bus_din = 16'hBEEF;
    run(1, 0, 24'h000003, 16'h0, 2'b11, 0, -5);
    chk_phases("type1 read R5", 1, 1, 4, 1, 1);
    chk(saw_ds && !saw_rd && !saw_wr && rnw_stb, "R5 read ds/rnw", {saw_ds, rnw_stb}, 3);
    chk(be_stb == 2'b10, "R8 narrow lanes", be_stb, 2'b10);
    chk(rv_data == 16'h00EF, "R8 narrow read data", rv_data, 16'h00EF);
    run(1, 1, 24'h000004, 16'h1234, 2'b11, 0, -5);
    chk(saw_ds && !saw_wr && !rnw_stb, "R5 write ds/rnw", {saw_ds, rnw_stb}, 2);
    chk(dout_stb == 16'h0034 && doe_stb, "R8 narrow write data", dout_stb, 16'h0034);
  endtask

  task automatic t_mux;
    setcs(2, 1, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    run(2, 0, 24'h123456, 16'h0, 2'b11, 0, -5);
    chk(doe_a && dout_a == 16'h3456, "R7 mux address on read", dout_a, 16'h3456);
    chk(!doe_stb, "R7 mux read released in strobe", doe_stb, 0);
    run(2, 1, 24'h123456, 16'hCAFE, 2'b11, 0, -5);
    chk(doe_a && dout_a == 16'h3456, "R7 mux address on write", dout_a, 16'h3456);
    chk(doe_stb && dout_stb == 16'hCAFE, "R7 mux data replaces address", dout_stb, 16'hCAFE);
  endtask

  task automatic t_wr_blocked;
    logic [OFFW-1:0] prev = bus_addr;
    int hits = 0;
    setcs(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_cs = 3; req_off = 24'h777777; req_wdata = 16'hFFFF;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || bus_cs_n != 8'hFF || !bus_wr_n || !bus_rd_n || !bus_ds_n || bus_doe) hits++;
    end
    req_valid = 0;
    chk(hits == 0, "R9 blocked write leaves bus idle", hits, 0);
    chk(bus_addr == prev, "R9 blocked write keeps address", bus_addr, prev);
  endtask

  task automatic t_byte_read;
    setcs(4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    setcs(5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    bus_din = 16'h9876;
    run(4, 0, 24'h000001, 16'h0, 2'b01, 0, -5);
    chk(be_stb == 2'b00, "R10 byte read widened", be_stb, 2'b00);
    chk(rv_data == 16'h9876, "R8 wide read data", rv_data, 16'h9876);
    run(5, 0, 24'h000001, 16'h0, 2'b10, 0, -5);
    chk(be_stb == 2'b01, "R10 byte read kept", be_stb, 2'b01);
  endtask

  task automatic t_hostport;
    setcs(6, 0, 0, 2, 0, 0, 2, 1, 0, 0, 1, 0);
    run(6, 0, 24'h000020, 16'h0, 2'b11, 5, -5);
    chk_phases("host ready at expiry R6", 1, 1, 3, 1, 1);
    chk(saw_ds && rnw_stb, "R6 host strobe style", {saw_ds, rnw_stb}, 3);
    run(6, 0, 24'h000020, 16'h0, 2'b11, 9, -5);
    chk(stb_last - stb_first + 1 == 7, "R6 late ready stretches strobe", stb_last - stb_first + 1, 7);
    chk(rv_k == stb_last + 1, "R12 rd_valid after stretched strobe", rv_k, stb_last + 1);
    setcs(6, 0, 0, 2, 0, 0, 3, 0, 0, 0, 1, 0);
    run(6, 0, 24'h000020, 16'h0, 2'b11, 8, -5);
    chk(stb_last - stb_first + 1 == 6, "R6 low polarity type 3", stb_last - stb_first + 1, 6);
  endtask

  task automatic t_busy_ignore;
    setcs(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    run(0, 0, 24'h000ABC, 16'h0, 2'b11, 0, 5);
    chk(n_busy == 5, "R11 busy length", n_busy, 5);
    @(negedge clk);
    chk(!busy, "R11 request in last recovery ignored", busy, 0);
    chk(bus_addr == 24'h000ABC, "R11 address unchanged", bus_addr, 24'h000ABC);
    run(0, 0, 24'h000ABD, 16'h0, 2'b11, 0, 2);
    @(negedge clk);
    chk(!busy && bus_addr == 24'h000ABD, "R11 mid-access request ignored", bus_addr, 24'h000ABD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_type0_read;
    t_type0_write_max;
    t_type1_narrow;
    t_mux;
    t_wr_blocked;
    t_byte_read;
    t_hostport;
    t_busy_ignore;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule